// File: doc/BRIEF.md
# Dual-Image Reconfiguration Controller

This block chooses which of two stored configuration images the device runs next: the factory image, which always sits at flash address zero, or an application image at a boot address that software programs. Software reaches it through a word-indexed register port with separate read and write strobes, a 6-bit index, 32-bit data and a wait signal. The controller asks an external image loader to start a load with a single-cycle request and a word address. The loader answers with a done strobe and a pass/fail flag.

Only the factory image may change the boot parameters or move to the application image. A switch that fails, a switch requested from the application image, and an expired watchdog all return the device to the factory image. A coded cause register then tells the factory software why it is running. It can use this to avoid retrying a broken application image forever.

Top module: `imgsw_ctrl`

## Requirements
- R1: After reset, index 0 reads 0 (factory image running) and index 15 reads 0x00 (cold start), provided `cfg_from_jtag` is low during reset.
- R2: Index 0 reads 1 while the application image runs and 0 otherwise. It changes only on the clock edge that ends the cycle in which the loader reports done.
- R3: In factory mode the following registers read back what was written. Index 2 is the watchdog limit in cycles: WD_W bits, reset value 1000. Index 3 is the watchdog enable in bit 0, reset value 1. Index 4 is the application boot word address (flash byte address shifted right by two): FLASH_AW-2 bits, reset value 0. Index 5, index 32 and every unmapped index read 0.
- R4: In factory mode, writing index 32 with bit 0 set raises `load_req` for exactly one cycle, with `load_addr` equal to the boot word address. If the loader passes, the mode becomes 1 and the cause becomes 0x00.
- R5: If the loader reports fail on a switch to the application image, the mode stays 0 and the cause becomes 0x08.
- R6: In application mode, writes to indices 2, 3 and 4 leave those registers unchanged.
- R7: In application mode, a trigger write raises `load_req` with `load_addr` 0. When the load completes, the mode becomes 0 and the cause becomes 0x01.
- R8: The watchdog fires when all of the following hold: the application image is running, the enable is set, and no write to index 5 has arrived for the limit number of cycles. It then requests a load from address 0, sets the mode to 0 and the cause to 0x04. When the enable is clear, it never fires.
- R9: A write to index 32 with bit 0 clear starts no load and changes no state.
- R10: A trigger write is stalled with `rp_wait` high from its first cycle. It completes, with `rp_wait` low, in the cycle in which the loader reports done. With a loader latency of L cycles after the request cycle, it therefore waits L+1 cycles.
- R11: If `cfg_from_jtag` is high during reset, index 15 reads 0x10 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_from_jtag | input | 1 | High during reset when the device was configured over the test port |
| rp_addr | input | 6 | Register word index |
| rp_rd | input | 1 | Read strobe, held until wait is low |
| rp_wr | input | 1 | Write strobe, held until wait is low |
| rp_wdata | input | 32 | Write data |
| rp_rdata | output | 32 | Read data, valid while reading with wait low |
| rp_wait | output | 1 | Stall for the current access |
| load_req | output | 1 | Single-cycle request to the image loader |
| load_addr | output | FLASH_AW-2 | Word address of the image to load |
| load_done | input | 1 | Loader has finished, one cycle |
| load_ok | input | 1 | Load succeeded, valid with load_done |

## Verification
The bench acts as the image loader with a programmable latency and verdict. It counts every request and records its address. This catches two kinds of error: a controller that pulses the request more than once, and one that sends the boot address when it should fall back to address zero. Counting the stalled cycles of a trigger write exposes a wait that drops one cycle early or late. Such a design would either complete the write before the outcome is known or retrigger itself. Reading the parameters back after writes made in application mode catches a missing mode guard. Letting the watchdog run out after a series of service writes catches a counter that never clears, or one that fires while disabled.

// File: rtl/imgsw_pkg.sv
package imgsw_pkg;

  localparam int IDX_W   = 6;
  localparam int DATA_W  = 32;
  localparam int CAUSE_W = 5;

  // Register indices seen by software
  localparam logic [IDX_W-1:0] IX_MODE    = 6'd0;
  localparam logic [IDX_W-1:0] IX_WD_TIME = 6'd2;
  localparam logic [IDX_W-1:0] IX_WD_EN   = 6'd3;
  localparam logic [IDX_W-1:0] IX_BOOT    = 6'd4;
  localparam logic [IDX_W-1:0] IX_KICK    = 6'd5;
  localparam logic [IDX_W-1:0] IX_CAUSE   = 6'd15;
  localparam logic [IDX_W-1:0] IX_TRIG    = 6'd32;

  // Reason codes for the last reconfiguration
  localparam logic [CAUSE_W-1:0] CAUSE_COLD    = 5'h00;
  localparam logic [CAUSE_W-1:0] CAUSE_SW_BACK = 5'h01;
  localparam logic [CAUSE_W-1:0] CAUSE_WDOG    = 5'h04;
  localparam logic [CAUSE_W-1:0] CAUSE_BAD_APP = 5'h08;
  localparam logic [CAUSE_W-1:0] CAUSE_JTAG    = 5'h10;

  typedef enum logic [1:0] {LD_IDLE, LD_REQ, LD_WAIT} ld_state_e;
  typedef enum logic [1:0] {SRC_TO_APP, SRC_SW_BACK, SRC_WDOG} ld_src_e;

  // Mode after a finished load
  function automatic logic next_mode(ld_src_e src, logic ok);
    return (src == SRC_TO_APP) && ok;
  endfunction

  // Cause after a finished load
  function automatic logic [CAUSE_W-1:0] next_cause(ld_src_e src, logic ok);
    logic [CAUSE_W-1:0] c;
    case (src)
      SRC_TO_APP:  c = ok ? CAUSE_COLD : CAUSE_BAD_APP;
      SRC_SW_BACK: c = CAUSE_SW_BACK;
      default:     c = CAUSE_WDOG;
    endcase
    return c;
  endfunction

  // Cause loaded by reset
  function automatic logic [CAUSE_W-1:0] boot_cause(logic via_jtag);
    return via_jtag ? CAUSE_JTAG : CAUSE_COLD;
  endfunction

  // Watchdog limit reached
  function automatic logic wd_due(logic [31:0] cnt, logic [31:0] lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/imgsw_regs.sv
module imgsw_regs
  import imgsw_pkg::*;
#(
  parameter int WORD_AW = 22,
  parameter int WD_W    = 16,
  parameter int WD_INIT = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_from_jtag,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                fin,
  input  ld_src_e             fin_src,
  input  logic                fin_ok,
  output logic                mode_app,
  output logic [CAUSE_W-1:0]  cause,
  output logic [WD_W-1:0]     wd_limit,
  output logic                wd_en,
  output logic [WORD_AW-1:0]  boot_word
);

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  // Parameter writes land only while the factory image runs
  logic param_wr;
  assign param_wr = wr_en && !mode_app;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_limit  <= WD_W'(WD_INIT);
      wd_en     <= 1'b1;
      boot_word <= '0;
    end else if (param_wr) begin
      case (wr_idx)
        IX_WD_TIME: wd_limit  <= wr_data[WD_W-1:0];
        IX_WD_EN:   wd_en     <= wr_data[0];
        IX_BOOT:    boot_word <= wr_data[WORD_AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_app <= 1'b0;
      cause    <= boot_cause(cfg_from_jtag);
    end else if (fin) begin
      mode_app <= next_mode(fin_src, fin_ok);
      cause    <= next_cause(fin_src, fin_ok);
    end
  end

endmodule

// File: rtl/imgsw_wdog.sv
module imgsw_wdog #(
  parameter int WD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            kick,
  input  logic [WD_W-1:0] limit,
  output logic            expire
);

  logic [WD_W-1:0] cnt;
  logic            cnt_max;

  assign cnt_max = &cnt;
  assign expire  = run && imgsw_pkg::wd_due(32'(cnt), 32'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || kick) cnt <= '0;
    else if (!cnt_max)          cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/imgsw_seq.sv
module imgsw_seq
  import imgsw_pkg::*;
#(
  parameter int WORD_AW = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  ld_src_e            start_src,
  input  logic [WORD_AW-1:0] start_addr,
  input  logic               load_done,
  input  logic               load_ok,
  output logic               load_req,
  output logic [WORD_AW-1:0] load_addr,
  output logic               busy,
  output logic               fin,
  output ld_src_e            fin_src,
  output logic               fin_ok,
  output logic               from_port
);

  ld_state_e state;

  assign load_req  = (state == LD_REQ);
  assign busy      = (state != LD_IDLE);
  assign fin       = (state == LD_WAIT) && load_done;
  assign fin_ok    = load_ok;
  assign from_port = (fin_src != SRC_WDOG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= LD_IDLE;
      fin_src   <= SRC_TO_APP;
      load_addr <= '0;
    end else begin
      case (state)
        LD_IDLE: if (start) begin
          state     <= LD_REQ;
          fin_src   <= start_src;
          load_addr <= start_addr;
        end
        LD_REQ:  state <= LD_WAIT;
        LD_WAIT: if (load_done) state <= LD_IDLE;
        default: state <= LD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/imgsw_ctrl.sv
module imgsw_ctrl
  import imgsw_pkg::*;
#(
  parameter int FLASH_AW = 24,
  parameter int WD_W     = 16,
  parameter int WD_INIT  = 1000,
  localparam int WORD_AW = FLASH_AW - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_from_jtag,
  input  logic [5:0]         rp_addr,
  input  logic               rp_rd,
  input  logic               rp_wr,
  input  logic [31:0]        rp_wdata,
  output logic [31:0]        rp_rdata,
  output logic               rp_wait,
  output logic               load_req,
  output logic [WORD_AW-1:0] load_addr,
  input  logic               load_done,
  input  logic               load_ok
);

  logic               mode_app, wd_en, busy, fin, fin_ok, from_port;
  logic [CAUSE_W-1:0] cause;
  logic [WD_W-1:0]    wd_limit;
  logic [WORD_AW-1:0] boot_word, start_addr;
  ld_src_e            fin_src, start_src;

  // Named events used by the checker
  logic acc, trig_hit, wd_fire, start, wr_ok, kick, wd_run;

  assign acc      = rp_rd || rp_wr;
  assign trig_hit = rp_wr && (rp_addr == IX_TRIG) && rp_wdata[0] && !busy;
  assign start    = trig_hit || wd_fire;
  assign start_src  = trig_hit ? (mode_app ? SRC_SW_BACK : SRC_TO_APP) : SRC_WDOG;
  assign start_addr = (start_src == SRC_TO_APP) ? boot_word : '0;

  // A trigger stalls until its own load ends; other accesses wait out any load
  assign rp_wait = acc && (busy ? !(fin && from_port) : trig_hit);
  assign wr_ok   = rp_wr && !rp_wait && !busy;
  assign kick    = wr_ok && (rp_addr == IX_KICK);
  assign wd_run  = mode_app && wd_en && !busy;

  always_comb begin
    rp_rdata = '0;
    if (rp_rd) begin
      case (rp_addr)
        IX_MODE:    rp_rdata = 32'(mode_app);
        IX_WD_TIME: rp_rdata = 32'(wd_limit);
        IX_WD_EN:   rp_rdata = 32'(wd_en);
        IX_BOOT:    rp_rdata = 32'(boot_word);
        IX_CAUSE:   rp_rdata = 32'(cause);
        default:    rp_rdata = '0;
      endcase
    end
  end

  imgsw_regs #(.WORD_AW(WORD_AW), .WD_W(WD_W), .WD_INIT(WD_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_from_jtag(cfg_from_jtag),
    .wr_en(wr_ok), .wr_idx(rp_addr), .wr_data(rp_wdata),
    .fin(fin), .fin_src(fin_src), .fin_ok(fin_ok),
    .mode_app(mode_app), .cause(cause), .wd_limit(wd_limit),
    .wd_en(wd_en), .boot_word(boot_word)
  );

  imgsw_wdog #(.WD_W(WD_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run(wd_run), .kick(kick),
    .limit(wd_limit), .expire(wd_fire)
  );

  imgsw_seq #(.WORD_AW(WORD_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_src(start_src),
    .start_addr(start_addr), .load_done(load_done), .load_ok(load_ok),
    .load_req(load_req), .load_addr(load_addr), .busy(busy), .fin(fin),
    .fin_src(fin_src), .fin_ok(fin_ok), .from_port(from_port)
  );

endmodule

// File: rtl/imgsw_ctrl_chk.sv
module imgsw_ctrl_chk #(
  parameter int WORD_AW = 22
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc,
  input logic               rp_wait,
  input logic               load_req,
  input logic [WORD_AW-1:0] load_addr,
  input logic               mode_app,
  input logic               fin,
  input logic [WORD_AW-1:0] boot_word,
  input logic [4:0]         cause
);

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !load_req);

  // R7
  back_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && mode_app) |-> (load_addr == '0));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(mode_app));

  // R6
  app_param_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_app |=> $stable(boot_word));

  // R10
  req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && acc) |-> rp_wait);

  // R5
  bad_app_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == 5'h08) |-> !mode_app);

endmodule

bind imgsw_ctrl imgsw_ctrl_chk #(.WORD_AW(WORD_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .rp_wait(rp_wait),
  .load_req(load_req), .load_addr(load_addr), .mode_app(mode_app),
  .fin(fin), .boot_word(boot_word), .cause(cause)
);

// File: tb/imgsw_ctrl_tb.sv
`timescale 1ns/1ps
module imgsw_ctrl_tb;
  localparam int WORD_AW = 22;
  localparam logic [31:0] APP_WORD = 32'h0040_0000 >> 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst_n, cfg_from_jtag, rp_rd, rp_wr, rp_wait;
  logic               load_req, load_done, load_ok;
  logic [5:0]         rp_addr;
  logic [31:0]        rp_wdata, rp_rdata;
  logic [WORD_AW-1:0] load_addr;

  imgsw_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_from_jtag(cfg_from_jtag),
    .rp_addr(rp_addr), .rp_rd(rp_rd), .rp_wr(rp_wr), .rp_wdata(rp_wdata),
    .rp_rdata(rp_rdata), .rp_wait(rp_wait), .load_req(load_req),
    .load_addr(load_addr), .load_done(load_done), .load_ok(load_ok)
  );

  int n_run = 0, n_fail = 0;
  int req_cnt = 0, resp_lat = 5;
  logic [31:0] req_addr = '0;
  logic resp_ok = 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Loader model
  initial begin
    load_done = 1'b0; load_ok = 1'b0;
    forever begin
      @(negedge clk);
      if (load_req === 1'b1) begin
        req_cnt++;
        req_addr = 32'(load_addr);
        repeat (resp_lat) @(negedge clk);
        load_ok = resp_ok; load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0; load_ok = 1'b0;
      end
    end
  end

  task automatic bus_wr(input int idx, input logic [31:0] d, output int waits);
    @(negedge clk);
    rp_addr = 6'(idx); rp_wdata = d; rp_wr = 1'b1; waits = 0;
    #1;
    while (rp_wait) begin waits++; @(negedge clk); #1; end
    @(negedge clk);
    rp_wr = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    int w;
    bus_wr(idx, d, w);
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    rp_addr = 6'(idx); rp_rd = 1'b1;
    #1;
    while (rp_wait) begin @(negedge clk); #1; end
    d = rp_rdata;
    @(negedge clk);
    rp_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
    logic [31:0] d;
    rd(idx, d);
    check(req, d, exp);
  endtask

  task automatic do_reset(input logic jtag);
    rp_rd = 0; rp_wr = 0; rp_addr = 0; rp_wdata = 0;
    cfg_from_jtag = jtag; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cfg_from_jtag = 1'b0;
  endtask

  task automatic go_app(input logic [31:0] en, input logic [31:0] lim);
    wr(2, lim); wr(3, en); wr(4, APP_WORD);
    resp_ok = 1'b1;
    wr(32, 1);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    check("R1 load_req idle", 32'(load_req), 0);
    rd_chk("R1 mode", 0, 0);
    rd_chk("R1 cause", 15, 0);
    rd_chk("R3 wd limit reset", 2, 1000);
    rd_chk("R3 wd enable reset", 3, 1);
    rd_chk("R3 boot reset", 4, 0);
    rd_chk("R3 unmapped 7", 7, 0);
    rd_chk("R3 kick reads 0", 5, 0);
    rd_chk("R3 trigger reads 0", 32, 0);
    rd_chk("R3 unmapped 63", 63, 0);
  endtask

  task automatic t_params;
    do_reset(1'b0);
    wr(2, 32'h1234); wr(3, 0); wr(4, APP_WORD);
    rd_chk("R3 wd limit", 2, 32'h1234);
    rd_chk("R3 wd enable", 3, 0);
    rd_chk("R3 boot", 4, APP_WORD);
    wr(4, 32'hFFFF_FFFF);
    rd_chk("R3 boot width", 4, 32'h003F_FFFF);
  endtask

  task automatic t_switch_ok;
    int w, c0;
    do_reset(1'b0);
    wr(3, 0); wr(4, APP_WORD);
    resp_ok = 1'b1; resp_lat = 5; c0 = req_cnt;
    bus_wr(32, 1, w);
    check("R10 trigger wait cycles", 32'(w), 6);
    check("R4 one request", 32'(req_cnt - c0), 1);
    check("R4 request address", req_addr, APP_WORD);
    rd_chk("R4 mode app", 0, 1);
    rd_chk("R4 cause cleared", 15, 0);
  endtask

  task automatic t_switch_bad;
    int c0;
    do_reset(1'b0);
    wr(3, 0); wr(4, APP_WORD);
    resp_ok = 1'b0; resp_lat = 3; c0 = req_cnt;
    wr(32, 1);
    check("R5 request made", 32'(req_cnt - c0), 1);
    check("R5 request address", req_addr, APP_WORD);
    rd_chk("R5 mode factory", 0, 0);
    rd_chk("R5 cause bad app", 15, 32'h08);
    resp_ok = 1'b1;
    wr(32, 1);
    rd_chk("R4 retry mode", 0, 1);
    rd_chk("R4 retry cause", 15, 0);
  endtask

  task automatic t_ignore;
    do_reset(1'b0);
    go_app(0, 1000);
    wr(4, 32'h55); wr(2, 7); wr(3, 1);
    rd_chk("R6 boot kept", 4, APP_WORD);
    rd_chk("R6 limit kept", 2, 1000);
    rd_chk("R6 enable kept", 3, 0);
    rd_chk("R6 still app", 0, 1);
  endtask

  task automatic t_back;
    int c0;
    do_reset(1'b0);
    go_app(0, 1000);
    c0 = req_cnt;
    wr(32, 1);
    check("R7 request made", 32'(req_cnt - c0), 1);
    check("R7 factory address", req_addr, 0);
    rd_chk("R7 mode factory", 0, 0);
    rd_chk("R7 cause", 15, 32'h01);
    wr(4, 32'h2000);
    rd_chk("R3 writable again", 4, 32'h2000);
  endtask

  task automatic t_zero_trig;
    int c0;
    do_reset(1'b0);
    wr(4, APP_WORD);
    c0 = req_cnt;
    wr(32, 0);
    repeat (10) @(negedge clk);
    check("R9 no request", 32'(req_cnt - c0), 0);
    rd_chk("R9 mode", 0, 0);
    rd_chk("R9 cause", 15, 0);
    go_app(0, 1000);
    c0 = req_cnt;
    wr(32, 2);
    repeat (10) @(negedge clk);
    check("R9 no request app", 32'(req_cnt - c0), 0);
    rd_chk("R9 app mode", 0, 1);
  endtask

  task automatic t_wdog;
    int c0;
    do_reset(1'b0);
    go_app(1, 20);
    c0 = req_cnt;
    for (int k = 0; k < 6; k++) begin
      repeat (8) @(negedge clk);
      wr(5, 0);
    end
    check("R8 kicked no request", 32'(req_cnt - c0), 0);
    rd_chk("R8 kicked still app", 0, 1);
    repeat (40) @(negedge clk);
    check("R8 expiry request", 32'(req_cnt - c0), 1);
    check("R8 expiry address", req_addr, 0);
    rd_chk("R8 mode factory", 0, 0);
    rd_chk("R8 cause watchdog", 15, 32'h04);
  endtask

  task automatic t_wdog_off;
    int c0;
    do_reset(1'b0);
    go_app(0, 5);
    c0 = req_cnt;
    repeat (100) @(negedge clk);
    check("R8 disabled no request", 32'(req_cnt - c0), 0);
    rd_chk("R8 disabled still app", 0, 1);
  endtask

  task automatic t_jtag;
    do_reset(1'b1);
    rd_chk("R11 cause jtag", 15, 32'h10);
    rd_chk("R11 mode factory", 0, 0);
  endtask

  logic done = 1'b0;

  initial begin
    t_reset();
    t_params();
    t_switch_ok();
    t_switch_bad();
    t_ignore();
    t_back();
    t_zero_trig();
    t_wdog();
    t_wdog_off();
    t_jtag();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule